// File: doc/BRIEF.md
# Sampling Pushbutton Debouncer

This block cleans up the level of a mechanical pushbutton whose contacts chatter for several milliseconds after each press or release. It does not wait for the input to hold still for a given number of cycles. Instead it looks at the button only once per long sampling interval, and that interval is chosen longer than the worst bounce time. A free-running interval counter produces a single-cycle sample strobe each time it wraps. A level register takes the button value only on that strobe, so the cleaned level can move at most once per interval and a chattering edge becomes a single transition.

The raw input first passes through a chain of flip-flops to resynchronise it. The chain length is a parameter and may be zero. The sampling interval is a compile-time parameter. The defaults are 500,000 cycles, which is 10 ms at a 50 MHz clock, and two synchroniser stages. The reset input is asynchronous and active-low. Its release is retimed inside the block, so the whole block leaves reset on a clock edge.

Top module: `button_sampler`

## Requirements
- R1: While `rst_n` is low, `btn_level` is 0, and it goes to 0 at once when `rst_n` falls, without waiting for a clock edge.
- R2: `btn_level` changes only on a sample edge. Sample edges are exactly SAMPLE_CYCLES clock edges apart, so the distance between any two changes of `btn_level` is a nonzero multiple of SAMPLE_CYCLES.
- R3: The internal sample strobe is high for exactly one cycle in every SAMPLE_CYCLES cycles. The interval count wraps to zero on the edge that ends the strobe.
- R4: The value taken at a sample edge is the raw level that was present SYNC_STAGES edges before it. With the default of 2 stages, a raw change presented before the edge two edges ahead of a sample edge is taken at that sample edge. A raw change presented only one edge ahead waits for the next sample edge.
- R5: If `rst_n` rises between edges c and c+1 and `btn_raw` is held at 1, the first sample edge is edge c+SAMPLE_CYCLES+2 and `btn_level` rises on that edge.
- R6: While `btn_raw` is held at the value `btn_level` already has, `btn_level` does not change.
- R7: A burst of toggles on `btn_raw` that is shorter than one interval and is followed by a steady level gives exactly one transition of `btn_level` within three intervals, and it ends at the steady level.
- R8: After a reset taken in the middle of operation, the interval count restarts. The R5 timing then holds again from the new release.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset; release retimed internally |
| btn_raw | input | 1 | Bouncing button level straight from the pin |
| btn_level | output | 1 | Debounced button level, registered |

## Verification
Every result of this block falls on a sample edge. The bench therefore recovers the sample phase from the port: it records the clock edge on which `btn_level` last moved, and the next sample edge is exactly SAMPLE_CYCLES edges later. Raw changes are placed a counted number of edges before a predicted sample edge: three edges ahead to prove capture, two edges ahead to prove deferral through the synchroniser. The change edge is then compared exactly with the expected one, or with the reset release edge plus SAMPLE_CYCLES+2. All outputs are read at the falling clock edge after the rising edge that should have moved them. The one asynchronous check, the clear on reset, is read 1 ns after `rst_n` falls.

// File: rtl/btn_pkg.sv
package btn_pkg;

  // 10 ms at 50 MHz
  localparam int unsigned DFLT_SAMPLE_CYCLES = 500_000;
  localparam int unsigned DFLT_SYNC_STAGES   = 2;

  // Width of a counter that must hold 0 .. n-1, never below one bit
  function automatic int unsigned count_width(input int unsigned n);
    int unsigned w;
    w = $clog2(n);
    return (w < 1) ? 1 : w;
  endfunction

endpackage

// File: rtl/btn_rst_sync.sv
module btn_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_ni
);

  logic stg1_q, stg1_d;
  logic stg2_q, stg2_d;

  always_comb begin
    stg1_d = 1'b1;
    stg2_d = stg1_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stg1_q <= 1'b0;
      stg2_q <= 1'b0;
    end else begin
      stg1_q <= stg1_d;
      stg2_q <= stg2_d;
    end
  end

  assign rst_ni = stg2_q;

endmodule

// File: rtl/btn_sample_timer.sv
module btn_sample_timer #(
  parameter int unsigned SAMPLE_CYCLES = btn_pkg::DFLT_SAMPLE_CYCLES,
  parameter int unsigned CNT_W         = btn_pkg::count_width(SAMPLE_CYCLES)
) (
  input  logic clk,
  input  logic rst_ni,
  output logic sample_tick
);

  localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(SAMPLE_CYCLES - 1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             wrap;

  always_comb begin
    wrap  = (cnt_q == LAST_CNT);
    cnt_d = wrap ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_d;
  end

  assign sample_tick = wrap;

  // R3
  cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    cnt_q <= LAST_CNT);

  // R3
  tick_single_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    sample_tick |=> !sample_tick);

  // R3
  tick_wrap_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    sample_tick |=> (cnt_q == '0));

endmodule

// File: rtl/btn_level_sampler.sv
module btn_level_sampler #(
  parameter int unsigned SYNC_STAGES = btn_pkg::DFLT_SYNC_STAGES
) (
  input  logic clk,
  input  logic rst_ni,
  input  logic raw_i,
  input  logic sample_tick,
  output logic level_o
);

  logic sync_out;

  generate
    if (SYNC_STAGES == 0) begin : g_nosync
      assign sync_out = raw_i;
    end else begin : g_sync
      logic [SYNC_STAGES-1:0] chain_q, chain_d;

      always_comb begin
        chain_d = SYNC_STAGES'({chain_q, raw_i});
      end

      always_ff @(posedge clk or negedge rst_ni) begin
        if (!rst_ni) chain_q <= '0;
        else         chain_q <= chain_d;
      end

      assign sync_out = chain_q[SYNC_STAGES-1];
    end
  endgenerate

  logic level_q, level_d;

  always_comb begin
    level_d = level_q;
    if (sample_tick) level_d = sync_out;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) level_q <= 1'b0;
    else         level_q <= level_d;
  end

  assign level_o = level_q;

  // R2
  change_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    (level_q != $past(level_q)) |-> $past(sample_tick));

  // R4
  capture_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    sample_tick |=> (level_q == $past(sync_out)));

endmodule

// File: rtl/button_sampler.sv
module button_sampler #(
  parameter int unsigned SAMPLE_CYCLES = btn_pkg::DFLT_SAMPLE_CYCLES,
  parameter int unsigned SYNC_STAGES   = btn_pkg::DFLT_SYNC_STAGES
) (
  input  logic clk,
  input  logic rst_n,
  input  logic btn_raw,
  output logic btn_level
);

  localparam int unsigned CNT_W = btn_pkg::count_width(SAMPLE_CYCLES);

  logic rst_ni;
  logic sample_tick;

  btn_rst_sync u_rst (
    .clk    (clk),
    .rst_n  (rst_n),
    .rst_ni (rst_ni)
  );

  btn_sample_timer #(
    .SAMPLE_CYCLES (SAMPLE_CYCLES),
    .CNT_W         (CNT_W)
  ) u_timer (
    .clk         (clk),
    .rst_ni      (rst_ni),
    .sample_tick (sample_tick)
  );

  btn_level_sampler #(
    .SYNC_STAGES (SYNC_STAGES)
  ) u_samp (
    .clk         (clk),
    .rst_ni      (rst_ni),
    .raw_i       (btn_raw),
    .sample_tick (sample_tick),
    .level_o     (btn_level)
  );

  // R1
  reset_low_chk: assert property (@(posedge clk)
    !rst_ni |-> !btn_level);

endmodule

// File: tb/sim_button_sampler.sv
module sim_button_sampler;

  localparam int N = 40;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic btn_raw = 1'b0;
  logic btn_level;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int nchg = 0;
  int last_edge = 0;
  bit have_last = 0;
  bit spacing_on = 0;
  logic prev = 1'b0;
  bit [15:0] lfsr = 16'hACE1;

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  button_sampler #(.SAMPLE_CYCLES(N), .SYNC_STAGES(2)) u0 (
    .clk(clk), .rst_n(rst_n), .btn_raw(btn_raw), .btn_level(btn_level)
  );

  task automatic report();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
    if (btn_level !== prev) begin
      nchg++;
      if (spacing_on && have_last)
        check(((cyc - last_edge) % N) == 0 && cyc != last_edge, "R2",
              "change spacing", cyc - last_edge, N);
      last_edge = cyc;
      have_last = 1;
      prev = btn_level;
    end
  endtask

  task automatic wait_cyc(input int e);
    while (cyc < e) step();
  endtask

  task automatic wait_change(input int limit, output int at, output bit got);
    int base;
    base = nchg;
    got = 0;
    at = -1;
    for (int i = 0; i < limit; i++) begin
      step();
      if (nchg != base) begin
        got = 1;
        at = last_edge;
        break;
      end
    end
  endtask

  task automatic lfsr_step();
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
  endtask

  int t_mark;

  // R1 and R5: level held low in reset, then rises on edge c+N+2
  task automatic t_reset_and_first();
    int at, c;
    bit got;
    btn_raw = 1'b1;
    for (int i = 0; i < 5; i++) step();
    check(btn_level === 1'b0, "R1", "level in reset", btn_level, 0);
    c = cyc;
    rst_n = 1'b1;
    wait_change(3 * N, at, got);
    check(got && at == c + N + 2, "R5", "first rise edge", at, c + N + 2);
    t_mark = at;
  endtask

  // R2: raw change well ahead is taken exactly one interval later
  task automatic t_period();
    int at;
    bit got;
    wait_cyc(t_mark + 3);
    btn_raw = 1'b0;
    wait_change(2 * N, at, got);
    check(got && at == t_mark + N, "R2", "fall edge", at, t_mark + N);
    t_mark = at;
  endtask

  // R4: one edge of lead is too short, change waits one more interval
  task automatic t_sync_short();
    int at;
    bit got;
    wait_cyc(t_mark + N - 2);
    btn_raw = 1'b1;
    wait_change(3 * N, at, got);
    check(got && at == t_mark + 2 * N, "R4", "late capture edge", at, t_mark + 2 * N);
    t_mark = at;
  endtask

  // R4: two edges of lead is enough for capture at the next sample edge
  task automatic t_sync_ok();
    int at;
    bit got;
    wait_cyc(t_mark + N - 3);
    btn_raw = 1'b0;
    wait_change(2 * N, at, got);
    check(got && at == t_mark + N, "R4", "timely capture edge", at, t_mark + N);
    t_mark = at;
  endtask

  // R6: steady raw equal to the level causes no change
  task automatic t_stable();
    int base;
    base = nchg;
    for (int i = 0; i < 3 * N; i++) step();
    check(nchg == base, "R6", "changes while steady", nchg - base, 0);
    check(btn_level === 1'b0, "R6", "level while steady", btn_level, 0);
  endtask

  // R7: short burst then steady 1 gives one transition
  task automatic t_burst();
    int base;
    base = nchg;
    for (int i = 0; i < N - 5; i++) begin
      lfsr_step();
      btn_raw = lfsr[0];
      step();
    end
    btn_raw = 1'b1;
    for (int i = 0; i < 3 * N; i++) step();
    check(nchg - base == 1, "R7", "transitions after burst", nchg - base, 1);
    check(btn_level === 1'b1, "R7", "level after burst", btn_level, 1);
  endtask

  // R2: long chatter, every change lies a multiple of N from the last
  task automatic t_chatter();
    have_last = 1;
    last_edge = t_mark;
    spacing_on = 1;
    for (int i = 0; i < 8 * N; i++) begin
      lfsr_step();
      btn_raw = lfsr[3];
      step();
    end
    spacing_on = 0;
    btn_raw = 1'b1;
    for (int i = 0; i < 3 * N; i++) step();
    check(btn_level === 1'b1, "R2", "level after chatter", btn_level, 1);
  endtask

  // R1 and R8: reset mid-run clears at once and restarts the interval
  task automatic t_midreset();
    int at, c;
    bit got;
    have_last = 0;
    rst_n = 1'b0;
    #1;
    check(btn_level === 1'b0, "R1", "async clear", btn_level, 0);
    for (int i = 0; i < 7; i++) step();
    c = cyc;
    rst_n = 1'b1;
    wait_change(3 * N, at, got);
    check(got && at == c + N + 2, "R8", "rise after restart", at, c + N + 2);
  endtask

  initial begin
    @(negedge clk);
    t_reset_and_first();
    t_period();
    t_sync_short();
    t_sync_ok();
    t_stable();
    t_burst();
    t_chatter();
    t_midreset();
    report();
  end

  initial begin
    #(20 * 20000);
    checks++;
    errors++;
    $display("FAIL watchdog expired at cycle %0d", cyc);
    report();
  end

endmodule